// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control unit for a single-bus processor datapath. A step counter first runs a three-step instruction fetch that is the same for every instruction. It then runs a short execute sequence chosen by the opcode. Each step produces one bundle of control strobes: bus drivers, register loads, the ALU operand mux select, ALU add, memory read, wait-for-memory and end-of-instruction. The datapath obeys these strobes. The block takes the opcode and the two register index fields from the instruction register, plus a memory-done acknowledge. It drives nothing else.

Memory reads use a request/acknowledge handshake. Each step that carries wait-for-memory holds the step counter until the acknowledge has been seen. During such a stall, the bus drivers and other level signals stay on. Strobes that change datapath state fire only in the first cycle of the step. Three instructions are supported: add register to register, add a memory operand through a pointer register, and load through a pointer register. Any other opcode ends right after the fetch.

Top module: `ctl_sequencer`

## Requirements
- R1: In fetch step 1 (the first cycle after reset or after an end) the strobes pc_drive, mar_load, mem_read, const4_sel, alu_add and y_load are high, and all other strobes are low.
- R2: In fetch step 2 the strobes y_drive, pc_load, y_load and mem_wait are high. mem_read is high while the fetch read is still unacknowledged.
- R3: In fetch step 3 only mdr_drive and ir_load are high.
- R4: For opcode 4'h1 (rd ← rd + rs) the execute steps are as follows. Step 4: gpr_drive (src) and x_load. Step 5: gpr_drive (dst), alu_add and y_load, with const4_sel low. Step 6: y_drive, gpr_load and instr_end.
- R5: For opcode 4'h2 (rd ← rd + mem[rs]) the execute steps are as follows. Step 4: gpr_drive (src), mar_load and mem_read. Step 5: gpr_drive (dst), x_load and mem_wait. Step 6: mdr_drive, alu_add and y_load. Step 7: y_drive, gpr_load and instr_end.
- R6: For opcode 4'h3 (rd ← mem[rs]) the execute steps are as follows. Step 4: gpr_drive (src), mar_load and mem_read. Step 5: mdr_ext_load and mem_wait. Step 6: mdr_drive, gpr_load and instr_end.
- R7: For any other opcode, step 4 raises only instr_end, and no register is written.
- R8: During a mem_wait step the step counter holds until the acknowledge is seen, and the level strobes stay high. The load strobes pc_load, y_load, x_load, mar_load, ir_load and gpr_load are high only in the first cycle of a step.
- R9: mem_read rises in a read step and stays high until mem_done is sampled high, then drops. An acknowledge that arrives before the wait step is remembered, so that wait step lasts one cycle.
- R10: In the cycle after instr_end is high, the sequencer is back in fetch step 1.
- R11: While rst is high every strobe is low. The first cycle after rst falls is fetch step 1.
- R12: gpr_drive_idx shows ir_src in step 4 and ir_dst in step 5. gpr_load_idx shows ir_dst. At most one bus driver is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | OPC_W | Opcode field of the instruction register |
| ir_src | input | RIDX_W | Source / pointer register index |
| ir_dst | input | RIDX_W | Destination register index |
| mem_done | input | 1 | Memory acknowledge for the pending read |
| pc_drive | output | 1 | PC onto the internal bus |
| pc_load | output | 1 | PC loads from the bus |
| mar_load | output | 1 | Address register loads from the bus |
| mdr_drive | output | 1 | Data register onto the internal bus |
| mdr_ext_load | output | 1 | Data register loads from the external bus |
| ir_load | output | 1 | Instruction register loads from the bus |
| x_load | output | 1 | Operand register X loads from the bus |
| y_load | output | 1 | Result register Y loads from the ALU |
| y_drive | output | 1 | Y onto the internal bus |
| const4_sel | output | 1 | ALU operand mux: 1 selects constant 4, 0 selects X |
| alu_add | output | 1 | ALU performs addition |
| mem_read | output | 1 | Memory read request |
| mem_wait | output | 1 | Step waits for memory completion |
| instr_end | output | 1 | Last step of the instruction |
| gpr_drive | output | 1 | A general register onto the bus |
| gpr_drive_idx | output | RIDX_W | Index of the driving register |
| gpr_load | output | 1 | A general register loads from the bus |
| gpr_load_idx | output | RIDX_W | Index of the loaded register |

## Verification
The bench builds the block with its defaults: a 4-bit opcode, 8 registers and a 7-step ceiling. This gives distinct source and destination indices (2 and 5). It also leaves opcode 4'hF free to take the unknown-opcode path. A bench memory answers after 1, 3 or 6 cycles of request. A latency of 3 puts exactly one stall cycle in every wait step. A latency of 1 acknowledges during the read step itself and exercises the remembered acknowledge. A latency of 6 gives a long stall, in which the one-shot loads must fire only once.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_ADD_RR  = 1;
  localparam int OP_ADD_IND = 2;
  localparam int OP_LOAD    = 3;

  typedef struct packed {
    logic pc_drive;
    logic pc_load;
    logic mar_load;
    logic mdr_drive;
    logic mdr_ext;
    logic ir_load;
    logic x_load;
    logic y_load;
    logic y_drive;
    logic c4_sel;
    logic alu_add;
    logic rd_step;
    logic wait_mem;
    logic fin;
    logic g_drive;
    logic g_sel_dst;
    logic g_load;
  } ctl_t;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import seq_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic              first,
  input  logic [OPC_W-1:0]  opcode,
  output ctl_t              ctl
);
  ctl_t raw;
  logic is_rr, is_ind, is_ld;

  assign is_rr  = (opcode == OPC_W'(OP_ADD_RR));
  assign is_ind = (opcode == OPC_W'(OP_ADD_IND));
  assign is_ld  = (opcode == OPC_W'(OP_LOAD));

  always_comb begin
    raw = '0;
    case (step)
      STEP_W'(1): begin
        raw.pc_drive = 1'b1; raw.mar_load = 1'b1; raw.rd_step = 1'b1;
        raw.c4_sel   = 1'b1; raw.alu_add  = 1'b1; raw.y_load  = 1'b1;
      end
      STEP_W'(2): begin
        raw.y_drive = 1'b1; raw.pc_load = 1'b1; raw.y_load = 1'b1;
        raw.wait_mem = 1'b1;
      end
      STEP_W'(3): begin
        raw.mdr_drive = 1'b1; raw.ir_load = 1'b1;
      end
      STEP_W'(4): begin
        if (is_rr) begin
          raw.g_drive = 1'b1; raw.x_load = 1'b1;
        end else if (is_ind || is_ld) begin
          raw.g_drive = 1'b1; raw.mar_load = 1'b1; raw.rd_step = 1'b1;
        end else begin
          raw.fin = 1'b1;
        end
      end
      STEP_W'(5): begin
        if (is_rr) begin
          raw.g_drive = 1'b1; raw.g_sel_dst = 1'b1;
          raw.alu_add = 1'b1; raw.y_load = 1'b1;
        end else if (is_ind) begin
          raw.g_drive = 1'b1; raw.g_sel_dst = 1'b1;
          raw.x_load = 1'b1; raw.wait_mem = 1'b1;
        end else if (is_ld) begin
          raw.mdr_ext = 1'b1; raw.wait_mem = 1'b1;
        end else begin
          raw.fin = 1'b1;
        end
      end
      STEP_W'(6): begin
        if (is_rr) begin
          raw.y_drive = 1'b1; raw.g_load = 1'b1; raw.fin = 1'b1;
        end else if (is_ind) begin
          raw.mdr_drive = 1'b1; raw.alu_add = 1'b1; raw.y_load = 1'b1;
        end else if (is_ld) begin
          raw.mdr_drive = 1'b1; raw.g_load = 1'b1; raw.fin = 1'b1;
        end else begin
          raw.fin = 1'b1;
        end
      end
      STEP_W'(7): begin
        if (is_ind) begin
          raw.y_drive = 1'b1; raw.g_load = 1'b1;
        end
        raw.fin = 1'b1;
      end
      default: raw.fin = 1'b1;
    endcase
  end

  // state-changing loads fire only in the first cycle of a step
  always_comb begin
    ctl          = raw;
    ctl.pc_load  = raw.pc_load  & first;
    ctl.mar_load = raw.mar_load & first;
    ctl.ir_load  = raw.ir_load  & first;
    ctl.x_load   = raw.x_load   & first;
    ctl.y_load   = raw.y_load   & first;
    ctl.g_load   = raw.g_load   & first;
  end
endmodule

// File: rtl/step_ctr.sv
module step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_wait,
  input  logic              is_end,
  input  logic              ack_ok,
  output logic [STEP_W-1:0] step,
  output logic              first
);
  logic              go;
  logic [STEP_W-1:0] step_n;

  assign go = !is_wait || ack_ok;

  always_comb begin
    if (is_end)  step_n = STEP_W'(1);
    else if (go) step_n = step + STEP_W'(1);
    else         step_n = step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= STEP_W'(1);
      first <= 1'b1;
    end else begin
      step  <= step_n;
      first <= go;
    end
  end

  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (is_wait && !ack_ok) |=> $stable(step));
endmodule

// File: rtl/mem_hs.sv
module mem_hs (
  input  logic clk,
  input  logic rst,
  input  logic rd_step,
  input  logic is_wait,
  input  logic mem_done,
  output logic mem_read,
  output logic ack_ok
);
  logic req_q, ack_q, ack_now;

  assign mem_read = rd_step | req_q;
  assign ack_now  = mem_read & mem_done;
  assign ack_ok   = ack_now | ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      req_q <= mem_read & ~mem_done;
      ack_q <= ack_ok & ~is_wait;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_read && !mem_done) |=> mem_read);
  p_req_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_read && mem_done) |=> !mem_read);
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import seq_pkg::*;
#(
  parameter int OPC_W    = 4,
  parameter int REG_CNT  = 8,
  parameter int MAX_STEP = 7,
  localparam int RIDX_W  = $clog2(REG_CNT),
  localparam int STEP_W  = $clog2(MAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  ir_opcode,
  input  logic [RIDX_W-1:0] ir_src,
  input  logic [RIDX_W-1:0] ir_dst,
  input  logic              mem_done,
  output logic              pc_drive,
  output logic              pc_load,
  output logic              mar_load,
  output logic              mdr_drive,
  output logic              mdr_ext_load,
  output logic              ir_load,
  output logic              x_load,
  output logic              y_load,
  output logic              y_drive,
  output logic              const4_sel,
  output logic              alu_add,
  output logic              mem_read,
  output logic              mem_wait,
  output logic              instr_end,
  output logic              gpr_drive,
  output logic [RIDX_W-1:0] gpr_drive_idx,
  output logic              gpr_load,
  output logic [RIDX_W-1:0] gpr_load_idx
);
  logic [STEP_W-1:0] step;
  logic              first, ack_ok, rd_int;
  ctl_t              ctl, gc;

  step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .is_wait(ctl.wait_mem), .is_end(ctl.fin),
    .ack_ok(ack_ok), .step(step), .first(first)
  );

  ctl_decode #(.OPC_W(OPC_W), .STEP_W(STEP_W)) u_dec (
    .step(step), .first(first), .opcode(ir_opcode), .ctl(ctl)
  );

  mem_hs u_mem (
    .clk(clk), .rst(rst), .rd_step(ctl.rd_step), .is_wait(ctl.wait_mem),
    .mem_done(mem_done), .mem_read(rd_int), .ack_ok(ack_ok)
  );

  assign gc = rst ? '0 : ctl;

  assign pc_drive      = gc.pc_drive;
  assign pc_load       = gc.pc_load;
  assign mar_load      = gc.mar_load;
  assign mdr_drive     = gc.mdr_drive;
  assign mdr_ext_load  = gc.mdr_ext;
  assign ir_load       = gc.ir_load;
  assign x_load        = gc.x_load;
  assign y_load        = gc.y_load;
  assign y_drive       = gc.y_drive;
  assign const4_sel    = gc.c4_sel;
  assign alu_add       = gc.alu_add;
  assign mem_read      = rd_int & ~rst;
  assign mem_wait      = gc.wait_mem;
  assign instr_end     = gc.fin;
  assign gpr_drive     = gc.g_drive;
  assign gpr_drive_idx = ctl.g_sel_dst ? ir_dst : ir_src;
  assign gpr_load      = gc.g_load;
  assign gpr_load_idx  = ir_dst;

  p_one_driver_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_drive, mdr_drive, y_drive, gpr_drive}) <= 1);
  p_pc_once_r8: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    instr_end |=> (pc_drive && mar_load && const4_sel));
endmodule

// File: tb/ctl_sequencer_bench.sv
module ctl_sequencer_bench;
  localparam int RW = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ir_opcode = 4'h1;
  logic [RW-1:0] ir_src = 3'd2, ir_dst = 3'd5;
  logic mem_done = 1'b0;
  logic pc_drive, pc_load, mar_load, mdr_drive, mdr_ext_load, ir_load;
  logic x_load, y_load, y_drive, const4_sel, alu_add, mem_read, mem_wait;
  logic instr_end, gpr_drive, gpr_load;
  logic [RW-1:0] gpr_drive_idx, gpr_load_idx;

  int checks = 0, fails = 0, lat = 3, rcnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ctl_sequencer u_ctl_sequencer (
    .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .ir_src(ir_src),
    .ir_dst(ir_dst), .mem_done(mem_done), .pc_drive(pc_drive),
    .pc_load(pc_load), .mar_load(mar_load), .mdr_drive(mdr_drive),
    .mdr_ext_load(mdr_ext_load), .ir_load(ir_load), .x_load(x_load),
    .y_load(y_load), .y_drive(y_drive), .const4_sel(const4_sel),
    .alu_add(alu_add), .mem_read(mem_read), .mem_wait(mem_wait),
    .instr_end(instr_end), .gpr_drive(gpr_drive),
    .gpr_drive_idx(gpr_drive_idx), .gpr_load(gpr_load),
    .gpr_load_idx(gpr_load_idx)
  );

  // memory: acknowledges after lat cycles of continuous request
  initial forever begin
    @(negedge clk);
    if (mem_read) begin
      rcnt = rcnt + 1;
      mem_done = (rcnt == lat);
    end else begin
      rcnt = 0;
      mem_done = 1'b0;
    end
  end

  function automatic logic [15:0] obs();
    return {pc_drive, pc_load, mar_load, mdr_drive, mdr_ext_load, ir_load,
            x_load, y_load, y_drive, const4_sel, alu_add, mem_read,
            mem_wait, instr_end, gpr_drive, gpr_load};
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp,
                     input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(obs(), 16'h0000, "R11 strobes in reset");
    rst = 1'b0;
    @(negedge clk);
    #1;
  endtask

  // {req, opcode, drive-idx-is-dst, expected strobes}; memory latency 3
  localparam int NV = 29;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1, 4'h1, 1'b0, 16'hA170},  // R1 fetch 1
    {4'd2, 4'h1, 1'b0, 16'h4198},  // R2 fetch 2
    {4'd8, 4'h1, 1'b0, 16'h0098},  // R8 stall in fetch 2
    {4'd3, 4'h1, 1'b0, 16'h1400},  // R3 fetch 3
    {4'd4, 4'h1, 1'b0, 16'h0202},  // R4 src to X
    {4'd4, 4'h1, 1'b1, 16'h0122},  // R4 dst + X
    {4'd4, 4'h1, 1'b0, 16'h0085},  // R4 Y to dst, end
    {4'd10,4'h2, 1'b0, 16'hA170},  // R10 restart
    {4'd2, 4'h2, 1'b0, 16'h4198},
    {4'd8, 4'h2, 1'b0, 16'h0098},
    {4'd3, 4'h2, 1'b0, 16'h1400},
    {4'd5, 4'h2, 1'b0, 16'h2012},  // R5 pointer to MAR
    {4'd5, 4'h2, 1'b1, 16'h021A},  // R5 dst to X, wait
    {4'd8, 4'h2, 1'b1, 16'h001A},  // R8 stall, x_load gone
    {4'd5, 4'h2, 1'b0, 16'h1120},  // R5 MDR + X
    {4'd5, 4'h2, 1'b0, 16'h0085},  // R5 Y to dst, end
    {4'd10,4'h3, 1'b0, 16'hA170},
    {4'd2, 4'h3, 1'b0, 16'h4198},
    {4'd8, 4'h3, 1'b0, 16'h0098},
    {4'd3, 4'h3, 1'b0, 16'h1400},
    {4'd6, 4'h3, 1'b0, 16'h2012},  // R6 pointer to MAR
    {4'd6, 4'h3, 1'b0, 16'h0818},  // R6 MDR from external, wait
    {4'd8, 4'h3, 1'b0, 16'h0818},  // R8 level strobes held
    {4'd6, 4'h3, 1'b0, 16'h1005},  // R6 MDR to dst, end
    {4'd10,4'hF, 1'b0, 16'hA170},
    {4'd2, 4'hF, 1'b0, 16'h4198},
    {4'd8, 4'hF, 1'b0, 16'h0098},
    {4'd3, 4'hF, 1'b0, 16'h1400},
    {4'd7, 4'hF, 1'b0, 16'h0004}   // R7 unknown: end only
  };

  initial begin
    lat = 3;
    do_reset();
    chk(obs(), 16'hA170, "R11 first cycle after reset");
    for (int i = 0; i < NV; i++) begin
      ir_opcode = VEC[i][20:17];
      #1;
      chk(obs(), VEC[i][15:0], $sformatf("R%0d vector %0d", VEC[i][24:21], i));
      if (gpr_drive)
        chk({13'd0, gpr_drive_idx}, {13'd0, VEC[i][16] ? ir_dst : ir_src},
            $sformatf("R12 drive index vector %0d", i));
      if (gpr_load)
        chk({13'd0, gpr_load_idx}, {13'd0, ir_dst}, "R12 load index");
      @(negedge clk);
      #1;
    end
    chk(obs(), 16'hA170, "R10 fetch after unknown opcode end");

    // early acknowledge during the read step
    lat = 1;
    ir_opcode = 4'h1;
    do_reset();
    chk(obs(), 16'hA170, "R9 fetch 1");
    @(negedge clk); #1;
    chk(obs(), 16'h4188, "R9 remembered ack, no stall");
    @(negedge clk); #1;
    chk(obs(), 16'h1400, "R9 fetch 3 follows");

    // long stall
    lat = 6;
    do_reset();
    chk(obs(), 16'hA170, "R8 fetch 1");
    begin
      int pcl = 0, wc = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); #1;
        pcl += int'(pc_load);
        wc  += int'(y_drive & mem_wait & mem_read);
      end
      chk(16'(pcl), 16'd1, "R8 pc_load pulses in long stall");
      chk(16'(wc), 16'd5, "R8 held wait cycles");
    end
    @(negedge clk); #1;
    chk(obs(), 16'h1400, "R8 advance after ack");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule